// File: doc/BRIEF.md
# ECAM Configuration Address Translator

This block turns a configuration request, given as bus number, device/function and register offset, into a byte address inside a flat enhanced configuration access window in memory space. It adds the packed offset `{bus, devfn, offset}` to a programmable 64-bit base. Then it decides whether the access is allowed at all. Allowed accesses go out on a memory-style request port and their completion comes back upstream. Refused accesses never leave the block: they complete on their own one cycle after acceptance and are flagged as errors.

The decision rests on four items of state, and all of them sit in a small register file beside the access path. The first is an enable bit. The second is the number of the root bus, where only device/function 0 exists. The third is a size field that names the last reachable bus. The fourth is the link-up input, which gates every bus other than the root bus. The register file also holds a read-only capability word and a read-only view of the two link status inputs. The block handles one access at a time.

Top module: `ecam_xlate`

## Requirements
- R1: An accepted access drives `mem_addr` = {base_hi, base_lo} + (bus << 20 | devfn << 12 | offset). The full 64-bit sum carries from the low base word into the high one.
- R2: On the root bus (control bits 15:8), an access with devfn 0 is allowed. Any other devfn is refused, whatever the link state.
- R3: An access to a bus other than the root bus is refused while `link_up` is low. `phy_ready` alone does not make it valid.
- R4: An access whose bus number is greater than the size field (control bits 20:16) is refused.
- R5: While the enable bit (control bit 0) is clear, every access is refused.
- R6: A refused access is never presented on the memory port. It completes (`up_done`, with `up_err` = 1) in the cycle after acceptance. A refused read returns 0xFFFFFFFF.
- R7: Register index 0 is the capability word. It reads 0x00000001 (present) and ignores writes.
- R8: Register index 1 is the control word: bit 0 is enable, bits 15:8 are the root bus and bits 20:16 are the size. It resets to 0x000C0000 and all other bits read 0.
- R9: Register indices 2 and 3 hold the low and high words of the window base. Both reset to 0.
- R10: Register index 4 is read-only. Bit 0 shows `link_up` and bit 1 shows `phy_ready`. Writes to it have no effect.
- R11: While `mem_ready` is low, `mem_valid` stays high and `mem_addr` holds still. An accepted write completes one cycle after the memory handshake. An accepted read completes one cycle after `mem_rvalid` and returns `mem_rdata`. Both complete with `up_err` = 0.
- R12: `up_ready` is low from acceptance until the cycle after `up_done`, so only one access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| link_up | input | 1 | Link is up |
| phy_ready | input | 1 | Physical layer ready |
| up_valid | input | 1 | Configuration access request |
| up_ready | output | 1 | Block can accept a request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_bus | input | 8 | Target bus number |
| up_devfn | input | 8 | Target device/function |
| up_reg | input | 12 | Register byte offset |
| up_wdata | input | 32 | Write data |
| up_done | output | 1 | Access completed (one-cycle pulse) |
| up_err | output | 1 | Completed access was refused |
| up_rdata | output | 32 | Read data of the completed access |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
A wrong validity decision shows up at the ports in two places one cycle after acceptance. The block either raises `up_done` with an error when it should have raised `mem_valid`, or the reverse. So an error in any term of the check is seen within a single cycle. A wrong packing or base addition only shows up in the value of `mem_addr`. The vectors therefore place distinct patterns in the bus, devfn and offset fields, and use a base that carries from the low word into the high one. Register state that has gone wrong, such as a lost enable, root or size field, has no visible effect until the next access that depends on it. For that reason each field is changed and then followed at once by an access that lands on the changed boundary.

// File: rtl/ecam_xlate.sv
module ecam_xlate #(
  parameter int BUS_W    = 8,
  parameter int FN_W     = 8,
  parameter int OFF_W    = 12,
  parameter int DW       = 32,
  parameter int SZ_W     = 5,
  parameter int SIZE_RST = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_wr,
  input  logic [2:0]           csr_addr,
  input  logic [31:0]          csr_wdata,
  output logic [31:0]          csr_rdata,
  input  logic                 link_up,
  input  logic                 phy_ready,
  input  logic                 up_valid,
  output logic                 up_ready,
  input  logic                 up_write,
  input  logic [BUS_W-1:0]     up_bus,
  input  logic [FN_W-1:0]      up_devfn,
  input  logic [OFF_W-1:0]     up_reg,
  input  logic [DW-1:0]        up_wdata,
  output logic                 up_done,
  output logic                 up_err,
  output logic [DW-1:0]        up_rdata,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic                 mem_write,
  output logic [63:0]          mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic                 mem_rvalid,
  input  logic [DW-1:0]        mem_rdata
);

  localparam int WIN_W    = BUS_W + FN_W + OFF_W;
  localparam int ROOT_LSB = 8;
  localparam int SZ_LSB   = 16;
  localparam logic [2:0] IX_CAP  = 3'd0;
  localparam logic [2:0] IX_CTL  = 3'd1;
  localparam logic [2:0] IX_BLO  = 3'd2;
  localparam logic [2:0] IX_BHI  = 3'd3;
  localparam logic [2:0] IX_LINK = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;

  st_t              state;
  logic             ctl_en;
  logic [BUS_W-1:0] ctl_root;
  logic [SZ_W-1:0]  ctl_size;
  logic [31:0]      base_lo, base_hi;
  logic             err_q;
  logic [DW-1:0]    rdata_q;

  // Register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_root <= '0;
      ctl_size <= SZ_W'(SIZE_RST);
      base_lo  <= '0;
      base_hi  <= '0;
    end else if (csr_wr) begin
      case (csr_addr)
        IX_CTL: begin
          ctl_en   <= csr_wdata[0];
          ctl_root <= csr_wdata[ROOT_LSB +: BUS_W];
          ctl_size <= csr_wdata[SZ_LSB +: SZ_W];
        end
        IX_BLO:  base_lo <= csr_wdata;
        IX_BHI:  base_hi <= csr_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      IX_CAP:  csr_rdata[0] = 1'b1;
      IX_CTL: begin
        csr_rdata[0]                 = ctl_en;
        csr_rdata[ROOT_LSB +: BUS_W] = ctl_root;
        csr_rdata[SZ_LSB +: SZ_W]    = ctl_size;
      end
      IX_BLO:  csr_rdata = base_lo;
      IX_BHI:  csr_rdata = base_hi;
      IX_LINK: csr_rdata[1:0] = {phy_ready, link_up};
      default: ;
    endcase
  end

  // Validity decision and address composition
  wire             root_hit = (up_bus == ctl_root);
  wire             in_range = (up_bus <= BUS_W'(ctl_size));
  wire             acc_ok   = ctl_en && in_range &&
                              (root_hit ? (up_devfn == '0) : link_up);
  wire [WIN_W-1:0] win_off  = {up_bus, up_devfn, up_reg};
  wire             accept   = up_valid && up_ready;

  assign up_ready  = (state == S_IDLE);
  assign mem_valid = (state == S_ISSUE);
  assign up_done   = (state == S_DONE);
  assign up_err    = err_q;
  assign up_rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      err_q     <= 1'b0;
      rdata_q   <= '0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          if (acc_ok) begin
            state     <= S_ISSUE;
            err_q     <= 1'b0;
            mem_write <= up_write;
            mem_addr  <= {base_hi, base_lo} + 64'(win_off);
            mem_wdata <= up_wdata;
          end else begin
            state   <= S_DONE;
            err_q   <= 1'b1;
            rdata_q <= '1;
          end
        end
        S_ISSUE: if (mem_ready) begin
          state   <= mem_write ? S_DONE : S_WAIT;
          rdata_q <= '0;
        end
        S_WAIT: if (mem_rvalid) begin
          state   <= S_DONE;
          rdata_q <= mem_rdata;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  refused_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !acc_ok |=> up_done && up_err && !mem_valid);
  // R5
  disabled_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ctl_en |=> up_done && up_err);
  // R3
  link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !root_hit && !link_up |=> up_err && !mem_valid);
  // R2
  root_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && root_hit && (up_devfn != '0) |=> up_err && !mem_valid);
  // R4
  bus_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_range |=> up_err && !mem_valid);
  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));
  // R12
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_done |-> !up_ready && !mem_valid);

endmodule

// File: tb/sim_ecam_xlate.sv
module sim_ecam_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        csr_wr = 0;
  logic [2:0]  csr_addr = 0;
  logic [31:0] csr_wdata = 0;
  logic [31:0] csr_rdata;
  logic        link_up = 0, phy_ready = 0;
  logic        up_valid = 0, up_ready, up_write = 0;
  logic [7:0]  up_bus = 0, up_devfn = 0;
  logic [11:0] up_reg = 0;
  logic [31:0] up_wdata = 0, up_rdata;
  logic        up_done, up_err;
  logic        mem_valid, mem_ready, mem_write, mem_rvalid;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0, grants = 0;
  logic        stall, lat_we;
  logic [63:0] lat_addr;
  logic [31:0] lat_wdata;
  bit          finished = 0;

  always #5 clk = ~clk;

  ecam_xlate u0 (.*);

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready <= 0; mem_rvalid <= 0; stall <= 0; mem_rdata <= 0;
      lat_we <= 0; lat_addr <= 0; lat_wdata <= 0;
    end else begin
      mem_rvalid <= 0;
      if (mem_ready && !lat_we) begin
        mem_rvalid <= 1;
        mem_rdata  <= lat_addr[31:0] ^ 32'hC0DE0000;
      end
      if (mem_valid && !mem_ready) begin
        if (!stall) stall <= 1;
        else begin
          stall <= 0; mem_ready <= 1; grants <= grants + 1;
          lat_we <= mem_write; lat_addr <= mem_addr; lat_wdata <= mem_wdata;
        end
      end else mem_ready <= 0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
    csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 0;
  endtask

  task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic access(input logic wr, input logic [7:0] bus, input logic [7:0] fn,
                        input logic [11:0] rg, input logic [31:0] wd,
                        output logic err, output logic [31:0] rd, output int lat,
                        output int fwd, output logic busy_bad);
    int n0, cyc;
    while (!up_ready) @(negedge clk);
    n0 = grants;
    up_valid = 1; up_write = wr; up_bus = bus; up_devfn = fn; up_reg = rg; up_wdata = wd;
    @(posedge clk); @(negedge clk);
    up_valid = 0;
    cyc = 1; busy_bad = 0;
    while (!up_done && cyc < 50) begin
      if (up_ready) busy_bad = 1;
      @(negedge clk); cyc++;
    end
    if (up_ready) busy_bad = 1;
    err = up_err; rd = up_rdata; lat = cyc; fwd = grants - n0;
  endtask

  // {wr, bus, devfn, reg, link, ok}
  localparam logic [30:0] VEC [10] = '{
    {1'b0, 8'd0,   8'h00, 12'h010, 1'b1, 1'b1},
    {1'b0, 8'd0,   8'h08, 12'h000, 1'b1, 1'b0},
    {1'b1, 8'd0,   8'h00, 12'h004, 1'b0, 1'b1},
    {1'b0, 8'd1,   8'h00, 12'h000, 1'b0, 1'b0},
    {1'b0, 8'd1,   8'h0A, 12'h100, 1'b1, 1'b1},
    {1'b1, 8'd12,  8'hFF, 12'hFFC, 1'b1, 1'b1},
    {1'b0, 8'd13,  8'h00, 12'h000, 1'b1, 1'b0},
    {1'b1, 8'd5,   8'h03, 12'h040, 1'b0, 1'b0},
    {1'b0, 8'd255, 8'h00, 12'h000, 1'b1, 1'b0},
    {1'b1, 8'd3,   8'h11, 12'h2A8, 1'b1, 1'b1}
  };

  task automatic run_one(input string tag, input logic wr, input logic [7:0] bus,
                         input logic [7:0] fn, input logic [11:0] rg, input logic ok,
                         input logic [63:0] base);
    logic e, bb; logic [31:0] rd; int lat, fwd; logic [63:0] ea;
    logic [31:0] wd;
    wd = {bus, fn, 4'h5, rg};
    access(wr, bus, fn, rg, wd, e, rd, lat, fwd, bb);
    ea = base + {36'd0, bus, fn, rg};
    chk({tag, " err R6"}, 64'(e), 64'(!ok));
    chk({tag, " forwarded R6"}, 64'(fwd), ok ? 64'd1 : 64'd0);
    chk({tag, " busy R12"}, 64'(bb), 64'd0);
    if (ok) begin
      chk({tag, " addr R1"}, lat_addr, ea);
      chk({tag, " latency R11"}, 64'(lat), wr ? 64'd3 : 64'd4);
      if (wr) chk({tag, " wdata R11"}, 64'(lat_wdata), 64'(wd));
      else    chk({tag, " rdata R11"}, 64'(rd), 64'(ea[31:0] ^ 32'hC0DE0000));
    end else begin
      chk({tag, " reject latency R6"}, 64'(lat), 64'd1);
      if (!wr) chk({tag, " reject rdata R6"}, 64'(rd), 64'hFFFFFFFF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk("reset up_ready R12", 64'(up_ready), 64'd1);
    chk("reset mem_valid R6", 64'(mem_valid), 64'd0);
    csr_read(3'd0, d); chk("cap reset R7", 64'(d), 64'h1);
    csr_read(3'd1, d); chk("ctl reset R8", 64'(d), 64'h000C0000);
    csr_read(3'd2, d); chk("base lo reset R9", 64'(d), 64'h0);
    csr_read(3'd3, d); chk("base hi reset R9", 64'(d), 64'h0);
    link_up = 0; phy_ready = 1;
    csr_read(3'd4, d); chk("link status R10", 64'(d), 64'h2);
    csr_write(3'd4, 32'h0);
    csr_read(3'd4, d); chk("link status write ignored R10", 64'(d), 64'h2);
    csr_write(3'd0, 32'h0);
    csr_read(3'd0, d); chk("cap write ignored R7", 64'(d), 64'h1);

    // disabled: root devfn 0 refused
    run_one("disabled R5", 1'b0, 8'd0, 8'd0, 12'h0, 1'b0, 64'd0);

    csr_write(3'd1, 32'hFFFFFFFF);
    csr_read(3'd1, d); chk("ctl writable bits R8", 64'(d), 64'h001FFF01);

    base = 64'h00000012_30000000;
    csr_write(3'd2, base[31:0]);
    csr_write(3'd3, base[63:32]);
    csr_read(3'd3, d); chk("base hi R9", 64'(d), 64'h12);
    csr_write(3'd1, 32'h000C0001);

    for (int i = 0; i < 10; i++) begin
      link_up = VEC[i][1];
      phy_ready = 1;
      run_one($sformatf("vec%0d R2 R3 R4", i), VEC[i][30], VEC[i][29:22],
              VEC[i][21:14], VEC[i][13:2], VEC[i][0], base);
    end

    // phy_ready alone does not open a non-root bus
    link_up = 0; phy_ready = 1;
    run_one("phy only R3", 1'b0, 8'd2, 8'd0, 12'h0, 1'b0, base);

    // size shrink to 3
    link_up = 1;
    csr_write(3'd1, 32'h00030001);
    run_one("size edge ok R4", 1'b0, 8'd3, 8'd0, 12'h8, 1'b1, base);
    run_one("size edge refused R4", 1'b1, 8'd4, 8'd0, 12'h8, 1'b0, base);

    // root moved to bus 2
    csr_write(3'd1, 32'h000C0201);
    run_one("new root devfn1 R2", 1'b0, 8'd2, 8'd1, 12'h0, 1'b0, base);
    run_one("new root devfn0 R2", 1'b1, 8'd2, 8'd0, 12'h0, 1'b1, base);
    link_up = 0;
    run_one("old root needs link R3", 1'b0, 8'd0, 8'd0, 12'h0, 1'b0, base);

    // carry into high base word
    link_up = 1;
    csr_write(3'd1, 32'h000C0001);
    base = 64'h00000000_FFFFF000;
    csr_write(3'd2, base[31:0]);
    csr_write(3'd3, 32'h0);
    run_one("carry R1", 1'b0, 8'd0, 8'd0, 12'h000, 1'b1, base);
    run_one("carry bus1 R1", 1'b1, 8'd1, 8'd0, 12'h000, 1'b1, base);

    // disable again
    csr_write(3'd1, 32'h000C0000);
    run_one("disable again R5", 1'b1, 8'd1, 8'd0, 12'h0, 1'b0, base);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule